// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the target side of a three-pin serial link: a target-enable line, a serial clock and one bidirectional data line. The data line is split at the port into an input, an output and an output-enable. The block turns each serial transfer into plain accesses on a parallel register-file port. That port carries an address, a clock/RAM space select, write data with a one-cycle write strobe, combinational read data, and one-cycle strobes that mark the start and the end of a transfer. The register file itself and the time-of-day counter are not part of this block.

All three serial pins are resynchronised into the fast system clock domain. Edges are detected there. The serial clock therefore has to stay in each phase for several system clocks. A transfer begins with an 8-bit command byte, sent least significant bit first. It then carries data bytes into the target or out of it, also least significant bit first. A transfer moves either one byte or a burst. A burst starts at location 0 and steps through the selected space, wrapping past its last location, until the target-enable line drops.

Top module: `tw_serial_target`

## Requirements
- R1: After reset, and while the target-enable input is low, the data output enable is 0 and no write, start or end strobe is issued.
- R2: The command byte arrives least significant bit first, with each bit taken on a serial clock rising edge. Its bit 0 set means read and clear means write. Bits 5..1 form the register address. Bit 6 set selects the RAM space and clear selects the clock space. Bit 7 is the write-enable flag.
- R3: In a single-byte write, the eight rising edges after the command form one data byte, least significant bit first. It produces exactly one one-cycle write strobe, at the commanded address and space. Any further serial clocks before the enable drops are ignored.
- R4: A write command whose bit 7 is 0 produces no write strobe.
- R5: In a read, bit 0 of the addressed byte is driven on the falling edge that ends the last command bit. The following bits go out on later falling edges, least significant bit first. In a single-byte read, further clocks send the same byte again.
- R6: The data output enable is cleared at every serial clock rising edge. It is set only on falling edges during the read data phase.
- R7: Command address 31 selects a burst. The burst starts at location 0 and advances one location per byte. After the last location it wraps to 0. The clock space has 8 locations (0..7) and the RAM space has 31 (0..30).
- R8: Lowering the target-enable input ends the transfer at once. A partly received data byte is never written, and the data output enable falls within SYNC_STAGES+2 system clocks.
- R9: A target-enable rise produces one one-cycle start strobe. A target-enable fall produces one one-cycle end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_en_i | input | 1 | Target enable; high frames a transfer |
| ser_clk_i | input | 1 | Serial clock |
| ser_d_i | input | 1 | Serial data, input side of the data pin |
| ser_d_o | output | 1 | Serial data, output side of the data pin |
| ser_d_oe_o | output | 1 | Output enable of the data pin |
| reg_addr_o | output | 5 | Register-file location |
| reg_ram_o | output | 1 | Space select: 1 RAM, 0 clock |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for reg_addr_o / reg_ram_o |
| xfer_start_o | output | 1 | One-cycle strobe on transfer start |
| xfer_end_o | output | 1 | One-cycle strobe on transfer end |

## Verification
The assertions check, on every cycle, the rules for releasing the data line: release after each rising edge, release after the enable drops, and drive only in the read phase. They also check that the write strobe lasts one cycle and happens only in the write phase, that the start and end strobes never coincide, and that the burst address steps and wraps at the right location. Only the bench scenarios can show the values: the bit order of commands and data, which byte lands at which location, that a disabled or aborted write leaves the register file untouched, and that a single read repeats its byte. It covers these with directed cases and a seeded random write-then-read sweep over both spaces.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int CMD_W  = 8;
   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] BURST_LOC = '1;

   typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WDATA, ST_RDATA} tw_state_e;

   // command byte as received: bit 7 down to bit 0
   typedef struct packed {
      logic              wr_en;
      logic              ram;
      logic [ADDR_W-1:0] addr;
      logic              read;
   } tw_cmd_t;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its delayed copy
   logic [WIDTH-1:0] pipe [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s <= STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= async_i;
         for (int s = 1; s <= STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign level_o = pipe[STAGES-1];
   assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];
   assign fall_o  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/tw_burst_addr.sv
module tw_burst_addr
   import tw_pkg::*;
#(
   parameter int CLK_REGS   = 8,
   parameter int RAM_BYTES  = 31,
   parameter bit BURST_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              ram_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_REGS - 1);
   localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_BYTES - 1);

   logic [ADDR_W-1:0] last, nxt;
   assign last = ram_i ? RAM_LAST : CLK_LAST;

   generate
      if (BURST_WRAP) begin : g_wrap
         assign nxt = (addr_o == last) ? '0 : addr_o + 1'b1;
      end else begin : g_hold
         assign nxt = (addr_o == last) ? addr_o : addr_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (load_i) addr_o <= load_addr_i;
      else if (step_i) addr_o <= nxt;
   end

   // R7
   burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && addr_o == last) |=> addr_o == (BURST_WRAP ? '0 : $past(addr_o)));
   // R7
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && addr_o != last) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/tw_serial_ctrl.sv
module tw_serial_ctrl
   import tw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lvl_i,
   input  logic              en_rise_i,
   input  logic              en_fall_i,
   input  logic              sck_rise_i,
   input  logic              sck_fall_i,
   input  logic              sd_lvl_i,
   input  logic [CMD_W-1:0]  rdata_i,
   output logic              sd_o,
   output logic              sd_oe_o,
   output logic              ram_o,
   output logic              load_o,
   output logic [ADDR_W-1:0] load_addr_o,
   output logic              step_o,
   output logic              we_o,
   output logic [CMD_W-1:0]  wdata_o,
   output logic              start_o,
   output logic              end_o
);
   tw_state_e        state;
   tw_cmd_t          cmd;
   logic [2:0]       bit_cnt;
   logic [CMD_W-1:0] shreg;
   logic             burst, wdone, rd_step;
   logic [CMD_W-1:0] shin;

   assign shin   = {sd_lvl_i, shreg[CMD_W-1:1]};
   assign ram_o  = cmd.ram;
   assign step_o = rd_step | (we_o & burst);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  cmd <= '0;  bit_cnt <= '0;  shreg <= '0;
         burst <= 1'b0;  wdone <= 1'b0;  rd_step <= 1'b0;
         sd_o <= 1'b0;  sd_oe_o <= 1'b0;  load_o <= 1'b0;  load_addr_o <= '0;
         we_o <= 1'b0;  wdata_o <= '0;  start_o <= 1'b0;  end_o <= 1'b0;
      end else begin
         we_o    <= 1'b0;
         load_o  <= 1'b0;
         rd_step <= 1'b0;
         start_o <= en_rise_i;
         end_o   <= en_fall_i;
         if (!en_lvl_i) begin
            state   <= ST_IDLE;
            sd_oe_o <= 1'b0;
         end else begin
            if (sck_rise_i) sd_oe_o <= 1'b0;
            unique case (state)
               ST_IDLE: begin
                  state   <= ST_CMD;
                  bit_cnt <= '0;
                  wdone   <= 1'b0;
               end
               ST_CMD: if (sck_rise_i) begin
                  shreg   <= shin;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == 3'd7) begin
                     cmd         <= tw_cmd_t'(shin);
                     burst       <= (shin[ADDR_W:1] == BURST_LOC);
                     load_o      <= 1'b1;
                     load_addr_o <= (shin[ADDR_W:1] == BURST_LOC) ? '0 : shin[ADDR_W:1];
                     state       <= shin[0] ? ST_RDATA : ST_WDATA;
                  end
               end
               ST_WDATA: if (sck_rise_i && !wdone) begin
                  shreg   <= shin;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == 3'd7) begin
                     we_o    <= cmd.wr_en;
                     wdata_o <= shin;
                     wdone   <= !burst;
                  end
               end
               ST_RDATA: if (sck_fall_i) begin
                  if (bit_cnt == 3'd0) begin
                     sd_o  <= rdata_i[0];
                     shreg <= rdata_i >> 1;
                  end else begin
                     sd_o  <= shreg[0];
                     shreg <= shreg >> 1;
                  end
                  sd_oe_o <= 1'b1;
                  bit_cnt <= bit_cnt + 1'b1;
                  rd_step <= (bit_cnt == 3'd7) && burst;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R8
   en_drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl_i |=> !sd_oe_o);
   // R6
   rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise_i |=> !sd_oe_o);
   // R6
   drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe_o |-> state == ST_RDATA);
   // R3
   we_in_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> state == ST_WDATA);
   // R3
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |=> !we_o);
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_o, end_o}));
endmodule

// File: rtl/tw_serial_target.sv
module tw_serial_target
   import tw_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CLK_REGS    = 8,
   parameter int RAM_BYTES   = 31,
   parameter bit BURST_WRAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_en_i,
   input  logic              ser_clk_i,
   input  logic              ser_d_i,
   output logic              ser_d_o,
   output logic              ser_d_oe_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_ram_o,
   output logic              reg_we_o,
   output logic [CMD_W-1:0]  reg_wdata_o,
   input  logic [CMD_W-1:0]  reg_rdata_i,
   output logic              xfer_start_o,
   output logic              xfer_end_o
);
   localparam int MAX_LOC = (1 << ADDR_W) - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CLK_REGS < 1 || CLK_REGS > MAX_LOC) begin : g_bad_clk
         $error("CLK_REGS out of range");
      end
      if (RAM_BYTES < 1 || RAM_BYTES > MAX_LOC) begin : g_bad_ram
         $error("RAM_BYTES out of range");
      end
   endgenerate

   // bit 2: enable, bit 1: serial clock, bit 0: data
   logic [2:0] lvl, rise, fall;
   logic              load, step;
   logic [ADDR_W-1:0] load_addr;

   tw_edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i({tgt_en_i, ser_clk_i, ser_d_i}),
      .level_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   tw_serial_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .en_lvl_i(lvl[2]), .en_rise_i(rise[2]), .en_fall_i(fall[2]),
      .sck_rise_i(rise[1]), .sck_fall_i(fall[1]), .sd_lvl_i(lvl[0]),
      .rdata_i(reg_rdata_i),
      .sd_o(ser_d_o), .sd_oe_o(ser_d_oe_o), .ram_o(reg_ram_o),
      .load_o(load), .load_addr_o(load_addr), .step_o(step),
      .we_o(reg_we_o), .wdata_o(reg_wdata_o),
      .start_o(xfer_start_o), .end_o(xfer_end_o)
   );

   tw_burst_addr #(.CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES), .BURST_WRAP(BURST_WRAP)) i_addr (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .load_addr_i(load_addr), .ram_i(reg_ram_o), .step_i(step),
      .addr_o(reg_addr_o)
   );
endmodule

// File: tb/test_tw_serial_target.sv
module test_tw_serial_target;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b0, sck = 1'b0, sd = 1'b0;
   logic sd_o, sd_oe, ram, we, xs, xe;
   logic [4:0] addr;
   logic [7:0] wdata, rdata;

   always #5 clk = ~clk;

   tw_serial_target i_tw_serial_target (
      .clk(clk), .rst_n(rst_n), .tgt_en_i(en), .ser_clk_i(sck), .ser_d_i(sd),
      .ser_d_o(sd_o), .ser_d_oe_o(sd_oe), .reg_addr_o(addr), .reg_ram_o(ram),
      .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata),
      .xfer_start_o(xs), .xfer_end_o(xe)
   );

   // register-file stand-in
   logic [7:0] clk_m [32];
   logic [7:0] ram_m [32];
   logic [7:0] exp_clk [32];
   logic [7:0] exp_ram [32];
   int we_cnt = 0, st_cnt = 0, end_cnt = 0;
   assign rdata = ram ? ram_m[addr] : clk_m[addr];

   always @(posedge clk) begin
      if (we) begin
         if (ram) ram_m[addr] <= wdata; else clk_m[addr] <= wdata;
         we_cnt <= we_cnt + 1;
      end
      if (xs) st_cnt <= st_cnt + 1;
      if (xe) end_cnt <= end_cnt + 1;
   end

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   function automatic logic [7:0] mk_cmd(bit rd, logic [4:0] a, bit rm, bit en_w);
      return {en_w, rm, a, rd};
   endfunction

   task automatic en_on(); en = 1'b1; tick(HALF); endtask
   task automatic en_off(); sck = 1'b0; en = 1'b0; tick(2 * HALF); endtask

   task automatic put_bit(bit b);
      sd = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
   endtask

   task automatic put_byte(logic [7:0] v);
      for (int i = 0; i < 8; i++) put_bit(v[i]);
   endtask

   // assumes the previous falling edge was just issued when first=1
   task automatic get_byte(bit first, output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         if (!(first && i == 0)) begin
            sck = 1'b1; tick(6);
            chk("R6 released after rise", sd_oe, 1'b0);
            tick(HALF - 6); sck = 1'b0;
         end
         tick(HALF);
         chk("R5 driving in read", sd_oe, 1'b1);
         v[i] = sd_o;
      end
   endtask

   task automatic wr1(bit rm, logic [4:0] a, logic [7:0] d);
      en_on(); put_byte(mk_cmd(1'b0, a, rm, 1'b1)); put_byte(d); en_off();
      if (rm) exp_ram[a] = d; else exp_clk[a] = d;
   endtask

   task automatic rd1(bit rm, logic [4:0] a, output logic [7:0] v);
      en_on(); put_byte(mk_cmd(1'b1, a, rm, 1'b1)); get_byte(1'b1, v); en_off();
   endtask

   initial begin
      logic [7:0] v, v2;
      int w0, s0, e0;
      logic [7:0] bd [32];
      void'($urandom(32'h5eed));
      for (int i = 0; i < 32; i++) begin
         clk_m[i] = 8'h00; ram_m[i] = 8'h00; exp_clk[i] = 8'h00; exp_ram[i] = 8'h00;
      end
      tick(4); rst_n = 1'b1; tick(4);
      // R1 reset state
      chk("R1 oe after reset", sd_oe, 1'b0);
      chk("R1 no strobes after reset", {we, xs, xe}, 3'b000);
      en = 1'b0; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
      chk("R1 idle clocks ignored", we_cnt, 0);

      // R2/R3 single writes into both spaces at the same location
      s0 = st_cnt; e0 = end_cnt;
      wr1(1'b1, 5'd5, 8'hA7);
      chk("R9 one start strobe", st_cnt - s0, 1);
      chk("R9 one end strobe", end_cnt - e0, 1);
      wr1(1'b0, 5'd5, 8'h3C);
      chk("R2 RAM space write", ram_m[5], 8'hA7);
      chk("R2 clock space write", clk_m[5], 8'h3C);

      // R3 extra clocks after the byte are ignored
      w0 = we_cnt;
      en_on(); put_byte(mk_cmd(1'b0, 5'd3, 1'b0, 1'b1)); put_byte(8'h96); put_byte(8'h5A); en_off();
      exp_clk[3] = 8'h96;
      chk("R3 one strobe despite extra clocks", we_cnt - w0, 1);
      chk("R3 first byte kept", clk_m[3], 8'h96);

      // R4 write flag clear
      w0 = we_cnt;
      en_on(); put_byte(mk_cmd(1'b0, 5'd5, 1'b1, 1'b0)); put_byte(8'h11); en_off();
      chk("R4 no strobe when bit7 clear", we_cnt - w0, 0);
      rd1(1'b1, 5'd5, v);
      chk("R4 RAM 5 unchanged", v, 8'hA7);

      // R5 single read repeats its byte
      en_on(); put_byte(mk_cmd(1'b1, 5'd3, 1'b0, 1'b1));
      get_byte(1'b1, v); get_byte(1'b0, v2); en_off();
      chk("R5 first read byte", v, 8'h96);
      chk("R5 retransmitted byte", v2, 8'h96);

      // R7 clock burst write of 9 bytes wraps to location 0
      w0 = we_cnt;
      en_on(); put_byte(mk_cmd(1'b0, 5'd31, 1'b0, 1'b1));
      for (int i = 0; i < 9; i++) begin
         bd[i] = 8'($urandom);
         put_byte(bd[i]);
      end
      en_off();
      for (int i = 0; i < 8; i++) exp_clk[i] = bd[i];
      exp_clk[0] = bd[8];
      chk("R7 clock burst strobes", we_cnt - w0, 9);
      chk("R7 clock burst wrap to 0", clk_m[0], bd[8]);
      chk("R7 clock burst last location", clk_m[7], bd[7]);

      // R7 RAM burst write 31 bytes, burst read 32 bytes
      en_on(); put_byte(mk_cmd(1'b0, 5'd31, 1'b1, 1'b1));
      for (int i = 0; i < 31; i++) begin
         bd[i] = 8'($urandom);
         exp_ram[i] = bd[i];
         put_byte(bd[i]);
      end
      en_off();
      en_on(); put_byte(mk_cmd(1'b1, 5'd31, 1'b1, 1'b1));
      for (int i = 0; i < 32; i++) begin
         get_byte(i == 0, v);
         chk("R7 RAM burst read", v, exp_ram[i % 31]);
      end
      en_off();

      // R8 abort during write data
      w0 = we_cnt;
      en_on(); put_byte(mk_cmd(1'b0, 5'd2, 1'b1, 1'b1));
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      en_off();
      chk("R8 partial byte not written", we_cnt - w0, 0);
      chk("R8 RAM 2 untouched", ram_m[2], exp_ram[2]);

      // R8 abort during read releases the line
      en_on(); put_byte(mk_cmd(1'b1, 5'd4, 1'b1, 1'b1));
      tick(HALF);
      chk("R5 first bit driven before abort", sd_oe, 1'b1);
      en = 1'b0; tick(4);
      chk("R8 line released after enable drop", sd_oe, 1'b0);
      tick(2 * HALF);

      // random single write then read back, both spaces
      for (int k = 0; k < 24; k++) begin
         bit rm = 1'($urandom);
         logic [4:0] a = rm ? 5'($urandom % 31) : 5'($urandom % 8);
         logic [7:0] d = 8'($urandom);
         wr1(rm, a, d);
         rd1(rm, a, v);
         chk("R3 R5 random write/read", v, rm ? exp_ram[a] : exp_clk[a]);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   end
endmodule